// File: doc/BRIEF.md
# Two-Pass Conversion Timing Sequencer

This block is the clocked controller of a subranging analog-to-digital converter that resolves a 16-bit result in two coarse passes. A rising edge on an asynchronous start line starts a fixed sequence of control strobes. In the first pass the input sample-and-hold freezes the signal and a coarse quantizer runs. Its result is loaded into the upper bits of a DAC, and the DAC and the residue amplifier are left to settle. In the second pass the residue path switches over and the residue sample-and-hold captures the error signal. The quantizer runs a second time, and the correction stage and the output latch are then strobed. The analog circuits and the arithmetic are outside this block. It produces only their timing.

The input sample-and-hold is released as soon as the residue stage holds. The front end therefore acquires the next sample while the second pass is still running. Every phase length is a parameter in clock cycles. An elaboration check rejects any set of lengths that is below one cycle or whose sum exceeds the conversion budget.

Top module: `tpc_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, busy is 1, res_sw_in is 1, and all other outputs (both hold lines, res_sw_out and every strobe) are 0. A reset in the middle of a conversion returns the outputs to this state.
- R2: A 0-to-1 change on conv_start, seen through a two-flop synchronizer, starts a conversion. busy is low from the third rising clock edge after the change. A start line that stays high starts no further conversion.
- R3: The conversion opens with an aperture phase of T_APERTURE cycles in which busy is 0 and in_sh_hold is still 0. in_sh_hold is 1 only while busy is 0.
- R4: The first pass follows the aperture in this order: coarse1_stb for T_COARSE1 cycles, dac_load_stb for T_DAC_LOAD cycles, a DAC settle interval of T_DAC_SETTLE cycles, then a residue settle interval of T_RES_SETTLE cycles. dac_lsb_clr is 1 from the DAC load through both settle intervals. At most one of the five strobes is 1 in any cycle.
- R5: The second pass opens with T_SWITCH cycles in which res_sw_in is 0, res_sw_out is 1 and in_sh_hold is still 1. On the next cycle res_sh_hold rises and in_sh_hold falls together. The two switch enables are never both 1.
- R6: After the handover, res_sh_hold stays 1 through T_RES_HOLD further cycles, then coarse2_stb for T_COARSE2 cycles, correct_stb for T_CORRECT cycles and latch_stb for T_LATCH cycles, in that order.
- R7: busy stays low for exactly the sum of all phase lengths. It returns to 1 in the cycle after the last latch_stb cycle, with all outputs back to their reset values. A start edge that arrives after that point is accepted at once.
- R8: A start edge that arrives while busy is 0 does not change the running sequence. It drives start_err high for exactly one cycle, three clock edges after the edge on conv_start.
- R9: The phase lengths must each be at least 1 and sum to no more than CONV_BUDGET, so busy is never low for more than CONV_BUDGET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Asynchronous start request; a rising edge starts a conversion |
| busy | output | 1 | 1 when idle, 0 while a conversion runs |
| in_sh_hold | output | 1 | Input sample-and-hold in hold (0 = track) |
| res_sh_hold | output | 1 | Residue sample-and-hold in hold (0 = track) |
| res_sw_in | output | 1 | Residue input switch enable (settling path) |
| res_sw_out | output | 1 | Residue output switch enable (second-pass path) |
| coarse1_stb | output | 1 | First coarse conversion strobe |
| coarse2_stb | output | 1 | Second coarse conversion strobe |
| dac_load_stb | output | 1 | Load coarse bits into the upper DAC bits |
| dac_lsb_clr | output | 1 | Forces the low DAC bits to zero |
| correct_stb | output | 1 | Error correction strobe |
| latch_stb | output | 1 | Output latch update strobe |
| start_err | output | 1 | One-cycle pulse: start edge refused while busy |

## Verification
The hardest case to reach is a start edge that lands on the last cycle of a conversion, or on the first idle cycle after it. The synchronizer delay decides whether such an edge is refused with start_err or accepted as the next conversion. The bench raises conv_start on the final latch cycle, so the synchronized edge reaches the controller on the first idle cycle. It then checks that the second conversion starts without an error pulse and that its full strobe trace matches the first one. A second sequence pokes the start line in the middle of the first pass. The trace must stay the same and exactly one error pulse must appear three edges later.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_APT,
        PH_CV1,
        PH_DLD,
        PH_DST,
        PH_RST,
        PH_SW,
        PH_RH,
        PH_CV2,
        PH_COR,
        PH_LAT
    } phase_e;

    typedef struct packed {
        logic busy;
        logic in_hold;
        logic res_hold;
        logic sw_in;
        logic sw_out;
        logic cv1;
        logic cv2;
        logic dld;
        logic lsb_clr;
        logic corr;
        logic lat;
    } ctl_t;

    // Successor in the fixed conversion order.
    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_IDLE: return PH_APT;
            PH_APT:  return PH_CV1;
            PH_CV1:  return PH_DLD;
            PH_DLD:  return PH_DST;
            PH_DST:  return PH_RST;
            PH_RST:  return PH_SW;
            PH_SW:   return PH_RH;
            PH_RH:   return PH_CV2;
            PH_CV2:  return PH_COR;
            PH_COR:  return PH_LAT;
            default: return PH_IDLE;
        endcase
    endfunction

    // Control word driven while a phase is active.
    function automatic ctl_t decode(input phase_e p);
        ctl_t c;
        c = '0;
        c.busy  = (p == PH_IDLE);
        c.sw_in = (p inside {PH_IDLE, PH_APT, PH_CV1, PH_DLD, PH_DST, PH_RST});
        c.sw_out = (p inside {PH_SW, PH_RH, PH_CV2, PH_COR, PH_LAT});
        c.in_hold = (p inside {PH_CV1, PH_DLD, PH_DST, PH_RST, PH_SW});
        c.res_hold = (p inside {PH_RH, PH_CV2, PH_COR, PH_LAT});
        c.cv1 = (p == PH_CV1);
        c.dld = (p == PH_DLD);
        c.lsb_clr = (p inside {PH_DLD, PH_DST, PH_RST});
        c.cv2 = (p == PH_CV2);
        c.corr = (p == PH_COR);
        c.lat = (p == PH_LAT);
        return c;
    endfunction

endpackage

// File: rtl/tpc_sync_edge.sv
module tpc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tpc_phase_timer.sv
module tpc_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/tpc_phase_fsm.sv
module tpc_phase_fsm
    import tpc_pkg::*;
#(
    parameter int CW           = 6,
    parameter int T_APERTURE   = 2,
    parameter int T_COARSE1    = 4,
    parameter int T_DAC_LOAD   = 1,
    parameter int T_DAC_SETTLE = 5,
    parameter int T_RES_SETTLE = 4,
    parameter int T_SWITCH     = 1,
    parameter int T_RES_HOLD   = 1,
    parameter int T_COARSE2    = 4,
    parameter int T_CORRECT    = 2,
    parameter int T_LATCH      = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_rise,
    input  logic          timer_done,
    output logic          adv,
    output logic [CW-1:0] load_val,
    output phase_e        phase_d,
    output logic          err_pulse
);
    phase_e phase_q;
    logic   err_q;

    always_comb begin
        adv     = (phase_q == PH_IDLE) ? start_rise : timer_done;
        phase_d = adv ? next_phase(phase_q) : phase_q;
    end

    // Cycles left after the entry cycle of the phase being entered.
    always_comb begin
        case (phase_d)
            PH_APT:  load_val = CW'(T_APERTURE - 1);
            PH_CV1:  load_val = CW'(T_COARSE1 - 1);
            PH_DLD:  load_val = CW'(T_DAC_LOAD - 1);
            PH_DST:  load_val = CW'(T_DAC_SETTLE - 1);
            PH_RST:  load_val = CW'(T_RES_SETTLE - 1);
            PH_SW:   load_val = CW'(T_SWITCH - 1);
            PH_RH:   load_val = CW'(T_RES_HOLD - 1);
            PH_CV2:  load_val = CW'(T_COARSE2 - 1);
            PH_COR:  load_val = CW'(T_CORRECT - 1);
            PH_LAT:  load_val = CW'(T_LATCH - 1);
            default: load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            err_q   <= start_rise && (phase_q != PH_IDLE);
        end
    end

    assign err_pulse = err_q;
endmodule

// File: rtl/tpc_strobe_map.sv
module tpc_strobe_map
    import tpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_d,
    output ctl_t   ctl
);
    // Registered decode keeps the analog-facing strobes glitch free.
    always_ff @(posedge clk) begin
        if (rst) ctl <= decode(PH_IDLE);
        else     ctl <= decode(phase_d);
    end
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
    import tpc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int T_APERTURE   = 2,
    parameter int T_COARSE1    = 4,
    parameter int T_DAC_LOAD   = 1,
    parameter int T_DAC_SETTLE = 5,
    parameter int T_RES_SETTLE = 4,
    parameter int T_SWITCH     = 1,
    parameter int T_RES_HOLD   = 1,
    parameter int T_COARSE2    = 4,
    parameter int T_CORRECT    = 2,
    parameter int T_LATCH      = 1,
    parameter int CONV_BUDGET  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    output logic busy,
    output logic in_sh_hold,
    output logic res_sh_hold,
    output logic res_sw_in,
    output logic res_sw_out,
    output logic coarse1_stb,
    output logic coarse2_stb,
    output logic dac_load_stb,
    output logic dac_lsb_clr,
    output logic correct_stb,
    output logic latch_stb,
    output logic start_err
);
    localparam int FIRST_SUM  = T_APERTURE + T_COARSE1 + T_DAC_LOAD + T_DAC_SETTLE + T_RES_SETTLE;
    localparam int SECOND_SUM = T_SWITCH + T_RES_HOLD + T_COARSE2 + T_CORRECT + T_LATCH;
    localparam int TOTAL      = FIRST_SUM + SECOND_SUM;
    localparam int MIN_LEN    = 1;
    localparam int CW         = $clog2(CONV_BUDGET + 1);
    localparam bit LEN_BAD    = (T_APERTURE < MIN_LEN) || (T_COARSE1 < MIN_LEN) ||
                                (T_DAC_LOAD < MIN_LEN) || (T_DAC_SETTLE < MIN_LEN) ||
                                (T_RES_SETTLE < MIN_LEN) || (T_SWITCH < MIN_LEN) ||
                                (T_RES_HOLD < MIN_LEN) || (T_COARSE2 < MIN_LEN) ||
                                (T_CORRECT < MIN_LEN) || (T_LATCH < MIN_LEN);

    // R9: elaboration-time budget check.
    generate
        if (LEN_BAD || (TOTAL > CONV_BUDGET) || (SYNC_STAGES < 2)) begin : g_cfg_bad
            $error("tpc_seq: phase lengths out of range or over the conversion budget");
        end
    endgenerate

    logic          start_rise;
    logic          timer_done;
    logic          adv;
    logic [CW-1:0] load_val;
    phase_e        phase_d;
    logic          err_pulse;
    ctl_t          ctl;

    tpc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (conv_start),
        .rise     (start_rise)
    );

    tpc_phase_fsm #(
        .CW           (CW),
        .T_APERTURE   (T_APERTURE),
        .T_COARSE1    (T_COARSE1),
        .T_DAC_LOAD   (T_DAC_LOAD),
        .T_DAC_SETTLE (T_DAC_SETTLE),
        .T_RES_SETTLE (T_RES_SETTLE),
        .T_SWITCH     (T_SWITCH),
        .T_RES_HOLD   (T_RES_HOLD),
        .T_COARSE2    (T_COARSE2),
        .T_CORRECT    (T_CORRECT),
        .T_LATCH      (T_LATCH)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_rise (start_rise),
        .timer_done (timer_done),
        .adv        (adv),
        .load_val   (load_val),
        .phase_d    (phase_d),
        .err_pulse  (err_pulse)
    );

    tpc_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (adv),
        .load_val (load_val),
        .done     (timer_done)
    );

    tpc_strobe_map u_map (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .ctl     (ctl)
    );

    assign busy         = ctl.busy;
    assign in_sh_hold   = ctl.in_hold;
    assign res_sh_hold  = ctl.res_hold;
    assign res_sw_in    = ctl.sw_in;
    assign res_sw_out   = ctl.sw_out;
    assign coarse1_stb  = ctl.cv1;
    assign coarse2_stb  = ctl.cv2;
    assign dac_load_stb = ctl.dld;
    assign dac_lsb_clr  = ctl.lsb_clr;
    assign correct_stb  = ctl.corr;
    assign latch_stb    = ctl.lat;
    assign start_err    = err_pulse;
endmodule

// File: rtl/tpc_seq_chk.sv
module tpc_seq_chk #(
    parameter int CONV_BUDGET = 32
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic in_sh_hold,
    input logic res_sh_hold,
    input logic res_sw_in,
    input logic res_sw_out,
    input logic coarse1_stb,
    input logic coarse2_stb,
    input logic dac_load_stb,
    input logic dac_lsb_clr,
    input logic correct_stb,
    input logic latch_stb,
    input logic start_err
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)        low_cnt <= '0;
        else if (!busy) low_cnt <= low_cnt + 1'b1;
        else            low_cnt <= '0;
    end

    p_hold_in_conv_r3: assert property (@(posedge clk) disable iff (rst)
        in_sh_hold |-> !busy);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({coarse1_stb, coarse2_stb, dac_load_stb, correct_stb, latch_stb}));

    p_lsb_in_first_r4: assert property (@(posedge clk) disable iff (rst)
        dac_lsb_clr |-> (in_sh_hold && !res_sh_hold));

    p_handover_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(res_sh_hold) |-> $fell(in_sh_hold));

    p_switch_first_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(res_sh_hold) |-> $past(res_sw_out));

    p_switch_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(res_sw_in && res_sw_out));

    p_latch_ends_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_stb) |-> busy);

    p_err_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        start_err |-> !$past(busy));

    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        start_err |=> !start_err);

    p_budget_r9: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= 16'(CONV_BUDGET));
endmodule

bind tpc_seq tpc_seq_chk #(.CONV_BUDGET(CONV_BUDGET)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .in_sh_hold   (in_sh_hold),
    .res_sh_hold  (res_sh_hold),
    .res_sw_in    (res_sw_in),
    .res_sw_out   (res_sw_out),
    .coarse1_stb  (coarse1_stb),
    .coarse2_stb  (coarse2_stb),
    .dac_load_stb (dac_load_stb),
    .dac_lsb_clr  (dac_lsb_clr),
    .correct_stb  (correct_stb),
    .latch_stb    (latch_stb),
    .start_err    (start_err)
);

// File: tb/tpc_seq_tb.sv
`timescale 1ns/1ps
module tpc_seq_tb;
    localparam int TA = 2, TC1 = 4, TDL = 1, TDS = 5, TRS = 4;
    localparam int TSW = 1, TRH = 1, TC2 = 4, TCO = 2, TLA = 1;
    localparam int BUDGET = 32;
    localparam int D = TA + TC1 + TDL + TDS + TRS + TSW + TRH + TC2 + TCO + TLA;
    localparam logic [10:0] V_IDLE = 11'b100_1000_0000;

    logic clk = 1'b0;
    logic rst;
    logic conv_start;
    logic busy, in_sh_hold, res_sh_hold, res_sw_in, res_sw_out;
    logic coarse1_stb, coarse2_stb, dac_load_stb, dac_lsb_clr;
    logic correct_stb, latch_stb, start_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    tpc_seq #(
        .SYNC_STAGES(2), .T_APERTURE(TA), .T_COARSE1(TC1), .T_DAC_LOAD(TDL),
        .T_DAC_SETTLE(TDS), .T_RES_SETTLE(TRS), .T_SWITCH(TSW), .T_RES_HOLD(TRH),
        .T_COARSE2(TC2), .T_CORRECT(TCO), .T_LATCH(TLA), .CONV_BUDGET(BUDGET)
    ) u_dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .busy(busy),
        .in_sh_hold(in_sh_hold), .res_sh_hold(res_sh_hold), .res_sw_in(res_sw_in),
        .res_sw_out(res_sw_out), .coarse1_stb(coarse1_stb), .coarse2_stb(coarse2_stb),
        .dac_load_stb(dac_load_stb), .dac_lsb_clr(dac_lsb_clr), .correct_stb(correct_stb),
        .latch_stb(latch_stb), .start_err(start_err)
    );

    // Bit order: busy, in hold, res hold, sw in, sw out, cv1, cv2, dac load, lsb clr, correct, latch
    function automatic logic [10:0] obs();
        return {busy, in_sh_hold, res_sh_hold, res_sw_in, res_sw_out,
                coarse1_stb, coarse2_stb, dac_load_stb, dac_lsb_clr, correct_stb, latch_stb};
    endfunction

    function automatic int phase_at(int i);
        int lens [10] = '{TA, TC1, TDL, TDS, TRS, TSW, TRH, TC2, TCO, TLA};
        int acc = 0;
        for (int p = 0; p < 10; p++) begin
            if (i < acc + lens[p]) return p;
            acc += lens[p];
        end
        return -1;
    endfunction

    function automatic logic [10:0] exp_at(int i);
        case (phase_at(i))
            0: return 11'b000_1000_0000;
            1: return 11'b010_1010_0000;
            2: return 11'b010_1000_1100;
            3: return 11'b010_1000_0100;
            4: return 11'b010_1000_0100;
            5: return 11'b010_0100_0000;
            6: return 11'b001_0100_0000;
            7: return 11'b001_0101_0000;
            8: return 11'b001_0100_0010;
            9: return 11'b001_0100_0001;
            default: return V_IDLE;
        endcase
    endfunction

    function automatic string req_at(int i);
        int p = phase_at(i);
        if (p == 0) return "R3";
        if (p <= 4) return "R4";
        if (p <= 6) return "R5";
        return "R6";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Caller raises conv_start at the current negedge (or did so one cycle earlier if at_n1).
    task automatic conv(input bit at_n1, input bit hold, input int poke, input bit rearm);
        int errs = 0;
        if (!at_n1) step();
        check(busy == 1'b1, "R2", "busy one edge after start", 32'(busy), 1);
        step();
        check(busy == 1'b1, "R2", "busy two edges after start", 32'(busy), 1);
        if (!hold) conv_start = 1'b0;
        step();
        for (int i = 0; i < D; i++) begin
            check(obs() == exp_at(i), req_at(i), $sformatf("trace cycle %0d", i),
                  32'(obs()), 32'(exp_at(i)));
            if (start_err) errs++;
            if (poke >= 0 && i == poke)     conv_start = 1'b1;
            if (poke >= 0 && i == poke + 2) conv_start = 1'b0;
            if (rearm && i == D - 1)        conv_start = 1'b1;
            step();
        end
        check(obs() == V_IDLE, "R7", "idle after conversion", 32'(obs()), 32'(V_IDLE));
        check(errs == (poke >= 0 ? 1 : 0), "R8", "error pulse count",
              32'(errs), (poke >= 0 ? 1 : 0));
    endtask

    task automatic t_reset();
        rst = 1'b1; conv_start = 1'b0;
        repeat (3) step();
        check(obs() == V_IDLE, "R1", "outputs in reset", 32'(obs()), 32'(V_IDLE));
        rst = 1'b0;
        step();
        check(obs() == V_IDLE && !start_err, "R1", "outputs after reset",
              32'({start_err, obs()}), 32'(V_IDLE));
    endtask

    task automatic t_single();
        conv_start = 1'b1;
        conv(1'b0, 1'b0, -1, 1'b0);
        repeat (3) step();
    endtask

    task automatic t_held();
        conv_start = 1'b1;
        conv(1'b0, 1'b1, -1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            check(busy == 1'b1, "R2", "held start gives no restart", 32'(busy), 1);
            step();
        end
        conv_start = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_poke();
        conv_start = 1'b1;
        conv(1'b0, 1'b0, 6, 1'b0);
        repeat (3) step();
    endtask

    task automatic t_back_to_back();
        conv_start = 1'b1;
        conv(1'b0, 1'b0, -1, 1'b1);
        conv(1'b1, 1'b0, -1, 1'b0);
        repeat (3) step();
    endtask

    task automatic t_mid_reset();
        conv_start = 1'b1;
        step(); step();
        conv_start = 1'b0;
        repeat (8) step();
        check(busy == 1'b0, "R1", "conversion running before reset", 32'(busy), 0);
        rst = 1'b1;
        step();
        check(obs() == V_IDLE, "R1", "reset mid conversion", 32'(obs()), 32'(V_IDLE));
        rst = 1'b0;
        repeat (2) step();
        check(obs() == V_IDLE, "R1", "idle after mid reset", 32'(obs()), 32'(V_IDLE));
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_single();
        t_held();
        t_poke();
        t_back_to_back();
        t_mid_reset();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule